// File: doc/BRIEF.md
# Shared-Exponent RGB Word Decoder

This block turns a packed 32-bit colour word into four IEEE-754 single-precision values. The word carries three unsigned 9-bit channel mantissas and one 5-bit exponent that all three channels share. Each colour channel is its integer mantissa multiplied by a power of two set by the shared exponent. The fourth output is an opacity channel that always reads 1.0. The mantissas have no hidden leading one, and the format has no sign, infinity or NaN codes. Every result is therefore a finite, nonnegative number, and the conversion is exact.

A producer presents a word together with a one-cycle strobe. Two clock edges later the three converted channels appear with a one-cycle valid pulse. A new word may be accepted on every cycle. Each channel is normalised with a leading-one search: the position of the highest set mantissa bit sets the float exponent, and the bits below it are left-aligned into the fraction field.

Top module: `sxd_rgb9e5_decode`

## Requirements
- R1: Field layout of `in_word`: red mantissa in bits 8:0, green in bits 17:9, blue in bits 26:18, and the unsigned shared exponent in bits 31:27.
- R2: Each colour output is the float32 encoding of mantissa × 2^(exponent − 24). The sign is 0, the exponent field is exponent + p + 103 (p is the index of the highest set mantissa bit), and the mantissa bits below bit p sit left-aligned in fraction bits 22:0.
- R3: A channel whose mantissa is zero yields exactly 0x00000000, whatever the shared exponent is.
- R4: `out_alpha` is always 0x3F800000 (1.0).
- R5: Every valid nonzero colour output has sign bit 0 and an exponent field that is neither 0 nor 255. No denormal, infinite or NaN result is produced; the smallest result is 2^-24 (0x33800000).
- R6: A word sampled with `in_vld` high produces `out_vld` high for exactly one cycle, on the second rising edge after sampling.
- R7: Words presented on consecutive cycles are each converted, and their results appear on consecutive cycles in input order.
- R8: While no new result is being delivered, the colour outputs hold their last values and `out_vld` stays low.
- R9: While `rst_n` is low, `out_vld` is low and all three colour outputs are 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Strobe marking `in_word` as valid |
| in_word | input | 32 | Packed word: three mantissas and the shared exponent |
| out_vld | output | 1 | One-cycle pulse marking the colour outputs as new |
| out_red | output | 32 | Red channel, float32 |
| out_green | output | 32 | Green channel, float32 |
| out_blue | output | 32 | Blue channel, float32 |
| out_alpha | output | 32 | Constant 1.0 in float32 |

## Verification
Results are due two rising edges after the strobe is sampled. The first edge registers the leading-one position and the shared exponent; the second registers the assembled floats and the valid pulse. The bench drives each word just after a falling edge and compares that word's outputs two falling edges later. When it streams the vector table back to back, the comparison for word i therefore happens while word i+2 is being driven. Directed tests sample one falling edge after a lone strobe to confirm that valid is still low, sample again to catch the pulse, and then idle for several cycles to confirm that the outputs hold.

// File: rtl/sxd_pkg.sv
package sxd_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FP_W      = 32;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_BIAS   = 127;

  localparam logic [FP_W-1:0] FP_ONE = 32'h3F80_0000;

  typedef struct packed {
    logic                 sign;
    logic [FP_EXP_W-1:0]  expo;
    logic [FP_FRAC_W-1:0] frac;
  } fp32_t;
endpackage

// File: rtl/sxd_lead_one.sv
module sxd_lead_one #(
  parameter  int W  = 9,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          any
);
  timeunit 1ns;
  timeprecision 1ps;

  // Highest set bit wins: later loop iterations overwrite earlier ones.
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos = PW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sxd_chan.sv
module sxd_chan
  import sxd_pkg::*;
#(
  parameter  int MANT_W     = 9,
  parameter  int EXP_W      = 5,
  parameter  int SHIFT_BIAS = 24,
  localparam int PW         = (MANT_W > 1) ? $clog2(MANT_W) : 1,
  localparam int FW1        = FP_FRAC_W + 1,
  localparam int SUM_W      = FP_EXP_W + 2,
  localparam int EXP_OFS    = FP_BIAS - SHIFT_BIAS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              emit_en,
  input  logic [MANT_W-1:0] mant_in,
  input  logic [EXP_W-1:0]  exp_q,
  output logic [FP_W-1:0]   result
);
  timeunit 1ns;
  timeprecision 1ps;

  // Stage A: leading-one search on the incoming mantissa.
  logic [MANT_W-1:0] mant_d, mant_q;
  logic [PW-1:0]     pos_d, pos_q;
  logic              nz_d, nz_q;

  sxd_lead_one #(.W(MANT_W)) u_lod (
    .vec (mant_in),
    .pos (pos_d),
    .any (nz_d)
  );

  always_comb mant_d = mant_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q <= '0;
      pos_q  <= '0;
      nz_q   <= 1'b0;
    end else if (load_en) begin
      mant_q <= mant_d;
      pos_q  <= pos_d;
      nz_q   <= nz_d;
    end
  end

  // Stage B: form the exponent field and left-align the fraction.
  logic [SUM_W-1:0] expo_sum;
  logic [4:0]       shamt;
  logic [FW1-1:0]   frac_full;
  fp32_t            res_d;
  logic [FP_W-1:0]  res_q;

  always_comb begin
    expo_sum  = SUM_W'(exp_q) + SUM_W'(pos_q) + SUM_W'(EXP_OFS);
    shamt     = 5'(FP_FRAC_W) - 5'(pos_q);
    frac_full = FW1'(mant_q) << shamt;
    res_d     = '0;
    if (nz_q) begin
      res_d.sign = 1'b0;
      res_d.expo = expo_sum[FP_EXP_W-1:0];
      res_d.frac = frac_full[FP_FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (emit_en) begin
      res_q <= res_d;
    end
  end

  assign result = res_q;

  // R3: a zero mantissa leaves stage B as an all-zero word
  a_r3_zero_mantissa: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_en && !nz_q) |=> (result == '0));

  // R5: nonzero results are positive, normal and finite
  a_r5_finite_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_en && nz_q) |=> (!result[FP_W-1] &&
                           result[FP_W-2:FP_FRAC_W] != '0 &&
                           result[FP_W-2:FP_FRAC_W] != '1));

  // R2: the fraction's leading one lands exactly at the hidden-bit slot
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    nz_q |-> frac_full[FP_FRAC_W]);
endmodule

// File: rtl/sxd_rgb9e5_decode.sv
module sxd_rgb9e5_decode
  import sxd_pkg::*;
#(
  parameter  int MANT_W     = 9,
  parameter  int EXP_W      = 5,
  parameter  int EXP_BIAS   = 15,
  localparam int N_CHAN     = 3,
  localparam int WORD_W     = N_CHAN * MANT_W + EXP_W,
  localparam int SHIFT_BIAS = EXP_BIAS + MANT_W,
  localparam int EXP_LSB    = N_CHAN * MANT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_vld,
  output logic [FP_W-1:0]   out_red,
  output logic [FP_W-1:0]   out_green,
  output logic [FP_W-1:0]   out_blue,
  output logic [FP_W-1:0]   out_alpha
);
  timeunit 1ns;
  timeprecision 1ps;

  // Stage A control and shared exponent
  logic             s1_vld_d, s1_vld_q;
  logic [EXP_W-1:0] s1_exp_d, s1_exp_q;
  logic             out_vld_d, out_vld_q;

  always_comb begin
    s1_vld_d  = in_vld;
    s1_exp_d  = in_word[EXP_LSB +: EXP_W];
    out_vld_d = s1_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      out_vld_q <= out_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_exp_q <= '0;
    end else if (in_vld) begin
      s1_exp_q <= s1_exp_d;
    end
  end

  // Channel lanes: lane 0 red, lane 1 green, lane 2 blue
  logic [FP_W-1:0] chan_res [N_CHAN];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_lane
    sxd_chan #(
      .MANT_W     (MANT_W),
      .EXP_W      (EXP_W),
      .SHIFT_BIAS (SHIFT_BIAS)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (in_vld),
      .emit_en (s1_vld_q),
      .mant_in (in_word[c*MANT_W +: MANT_W]),
      .exp_q   (s1_exp_q),
      .result  (chan_res[c])
    );
  end

  assign out_vld   = out_vld_q;
  assign out_red   = chan_res[0];
  assign out_green = chan_res[1];
  assign out_blue  = chan_res[2];
  assign out_alpha = FP_ONE;

  // R6: a sampled word reaches stage A on the next edge
  a_r6_stage_a: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> s1_vld_q);

  // R6: stage A content emerges as a valid result one edge later
  a_r6_stage_b: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |=> out_vld);

  // R6 / R8: no valid pulse without a word in flight
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld_q |=> !out_vld);

  // R8: colour outputs hold when nothing new is delivered
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld_q |=> ($stable(out_red) && $stable(out_green) && $stable(out_blue)));
endmodule

// File: tb/sxd_rgb9e5_decode_test.sv
module sxd_rgb9e5_decode_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] in_word;
  logic        out_vld;
  logic [31:0] out_red, out_green, out_blue, out_alpha;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  sxd_rgb9e5_decode uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_word   (in_word),
    .out_vld   (out_vld),
    .out_red   (out_red),
    .out_green (out_green),
    .out_blue  (out_blue),
    .out_alpha (out_alpha)
  );

  always #10 clk = ~clk;

  // {word, red, green, blue}, expected values worked out by hand from R2
  localparam int NV = 7;
  localparam logic [127:0] VEC [NV] = '{
    {32'hC00C0401, 32'h3F800000, 32'h40000000, 32'h40400000},
    {32'hC40001FF, 32'h43FF8000, 32'h00000000, 32'h43800000},
    {32'h0003FE01, 32'h33800000, 32'h37FF8000, 32'h00000000},
    {32'hFFFC03FF, 32'h477F8000, 32'h43000000, 32'h477F8000},
    {32'hF8000000, 32'h00000000, 32'h00000000, 32'h00000000},
    {32'h801C0C05, 32'h3CA00000, 32'h3CC00000, 32'h3CE00000},
    {32'h7C015555, 32'h3F2A8000, 32'h3EAA0000, 32'h3F000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    in_vld  = 1'b0;
    in_word = '0;
    repeat (3) @(negedge clk);
    // R9: state held in reset
    chk("R9 reset out_vld", 32'(out_vld), 32'd0);
    chk("R9 reset red",     out_red,   32'h0);
    chk("R9 reset green",   out_green, 32'h0);
    chk("R9 reset blue",    out_blue,  32'h0);
    chk("R4 alpha in reset", out_alpha, 32'h3F800000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 R7: table streamed back to back
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk("R7 stream valid", 32'(out_vld), 32'd1);
        chk("R1 R2 red",   out_red,   VEC[i-2][95:64]);
        chk("R1 R2 green", out_green, VEC[i-2][63:32]);
        chk("R1 R3 blue",  out_blue,  VEC[i-2][31:0]);
        chk("R5 sign clear", 32'(out_red[31] | out_green[31] | out_blue[31]), 32'd0);
        chk("R4 alpha", out_alpha, 32'h3F800000);
      end
      if (i < NV) begin
        in_vld  = 1'b1;
        in_word = VEC[i][127:96];
      end else begin
        in_vld  = 1'b0;
        in_word = 32'hFFFF_FFFF;
      end
      @(negedge clk);
    end

    // R8: idle cycles keep the last result
    repeat (3) @(negedge clk);
    chk("R8 idle valid low", 32'(out_vld), 32'd0);
    chk("R8 hold red",   out_red,   VEC[NV-1][95:64]);
    chk("R8 hold green", out_green, VEC[NV-1][63:32]);
    chk("R8 hold blue",  out_blue,  VEC[NV-1][31:0]);

    // R6: lone strobe, pulse exactly on the second edge
    in_vld  = 1'b1;
    in_word = 32'hC00C0401;
    @(negedge clk);
    in_vld  = 1'b0;
    in_word = 32'h0;
    chk("R6 not after one edge", 32'(out_vld), 32'd0);
    @(negedge clk);
    chk("R6 valid after two edges", 32'(out_vld), 32'd1);
    chk("R6 red", out_red, 32'h3F800000);
    @(negedge clk);
    chk("R6 single pulse", 32'(out_vld), 32'd0);
    chk("R8 red held after pulse", out_red, 32'h3F800000);

    // R3: large exponent with zero red and blue mantissas
    in_vld  = 1'b1;
    in_word = 32'hF8000400;   // exponent 31, green 2
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    chk("R3 zero red high exp",  out_red,   32'h0);
    chk("R2 green exp 31",       out_green, 32'h43800000);
    chk("R3 zero blue high exp", out_blue,  32'h0);

    // R9: reset with a word in flight
    in_vld  = 1'b1;
    in_word = 32'hFFFC03FF;
    @(negedge clk);
    in_vld = 1'b0;
    rst_n  = 1'b0;
    #2;
    chk("R9 mid reset valid", 32'(out_vld), 32'd0);
    chk("R9 mid reset red",   out_red, 32'h0);
    @(negedge clk);
    chk("R9 flight dropped", 32'(out_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 nothing after release", 32'(out_vld), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule